// File: doc/BRIEF.md
# I2C Bus Error and Time-out Handler

This block keeps the three sticky bus-error flags of an I2C controller and drives the recovery actions that follow a bus fault. Its inputs are a bus time-out strobe, a bus-collision strobe, the SDA level sampled at the ninth SCL pulse, four internal buffer-fault statuses, the client-active and host-active mode bits, a host/client mode select and a recovery-enable switch. It does not count time-outs and does not drive the bus. Those jobs belong to a separate time-out counter and to the bit-level protocol engine. Both talk to this block through single-cycle strobes and level signals.

Recovery after a time-out depends on the mode. In client mode with recovery on, the block resets the module and drops client-active and clock stretching. In host mode, the block drops host-data-ready. It then raises a stop request, either at once (recovery on) or after software asks for a stop (recovery off). The stop request is withheld while a client holds SCL low. The request ends when the host engine reports that the stop is done, and host-active is cleared one cycle later. Any internal buffer fault forces an automatic NACK and raises the combined error interrupt whatever the enables are.

Top module: `i2c_err_recovery`

## Requirements
- R1: After reset every output is 0. `err_flags_o` bit 0 is time-out, bit 1 is collision and bit 2 is NACK. A flag sets on the cycle after its event and stays set until the matching `flag_clr_i` bit is 1. When a set and a clear arrive in the same cycle, the flag stays set.
- R2: `err_irq_o` is 1 whenever a flag is set and its `irq_en_i` bit is 1, in the same cycle. It is 0 when no enabled flag is set and no buffer fault is pending (R10).
- R3: In client mode (`host_mode_i`=0) with `recov_en_i`=1, a time-out strobe pulses `clr_client_act_o` and `clr_clk_stretch_o` for one cycle on the next cycle. It also pulses `soft_rst_o`, whatever `client_act_i` is.
- R4: In client mode with `recov_en_i`=0, a time-out only sets the time-out flag. No reset, no clear and no stop request is produced.
- R5: In host mode (`host_mode_i`=1) with `host_act_i`=1, a time-out pulses `clr_host_rdy_o` for one cycle on the next cycle. With `host_act_i`=0 it only sets the flag.
- R6: In host mode with recovery on and the host active, a time-out starts a stop request on the next cycle. `stop_req_o` is a level that is forced to 0 while `scl_held_i`=1 and returns as soon as the clock is released.
- R7: In host mode with recovery off and the host active, the stop request starts on the cycle after `stop_cmd_i`. `stop_cmd_i` is ignored when no time-out is waiting for it.
- R8: `stop_done_i` during a stop request ends the request on the next cycle. On that same next cycle `clr_host_act_o` pulses for one cycle.
- R9: The NACK flag sets when `ninth_pulse_i`=1, `sda_i`=1 and `client_act_i` or `host_act_i` is 1. The flag does not set if both mode bits are 0 or if SDA is low.
- R10: A rising edge on any `buf_fault_i` bit pulses `auto_nack_o` for one cycle on the next cycle and sets the NACK flag. It also holds `err_irq_o` at 1 regardless of `irq_en_i` until the NACK flag is cleared. The bit order of `buf_fault_i` is: 0 transmit write error, 1 receive read error, 2 transmit underflow, 3 receive overflow.
- R11: `soft_rst_o` never stays high for two cycles in a row, even under back-to-back time-outs. The error flags are not cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmo_i | input | 1 | Bus time-out strobe |
| coll_i | input | 1 | Bus-collision strobe |
| ninth_pulse_i | input | 1 | Strobe at the ninth SCL pulse |
| sda_i | input | 1 | SDA level at the ninth pulse |
| buf_fault_i | input | 4 | Buffer fault statuses |
| client_act_i | input | 1 | Client-active mode bit |
| host_act_i | input | 1 | Host-active mode bit |
| host_mode_i | input | 1 | 1 host mode, 0 client mode |
| recov_en_i | input | 1 | Time-out auto-recovery enable |
| stop_cmd_i | input | 1 | Software stop command |
| stop_done_i | input | 1 | Stop generated by the host engine |
| scl_held_i | input | 1 | A client holds SCL low |
| flag_clr_i | input | 3 | Write-one clear of the error flags |
| irq_en_i | input | 3 | Per-flag interrupt enables |
| err_flags_o | output | 3 | Sticky error flags |
| err_irq_o | output | 1 | Combined error interrupt flag |
| soft_rst_o | output | 1 | Module soft-reset pulse |
| clr_client_act_o | output | 1 | Clear client-active pulse |
| clr_clk_stretch_o | output | 1 | Clear clock-stretch pulse |
| clr_host_rdy_o | output | 1 | Clear host-data-ready pulse |
| stop_req_o | output | 1 | Stop-generation request level |
| clr_host_act_o | output | 1 | Clear host-active pulse |
| auto_nack_o | output | 1 | Automatic NACK request pulse |

## Verification
A wrong recovery state would show at the ports within one cycle. A state machine stuck in its wait state raises `stop_req_o` without a time-out, or fails to raise it after `stop_cmd_i`. A machine that never leaves its stop state holds `stop_req_o` and never pulses `clr_host_act_o`. A wrong flag or pending-fault bit appears in the same cycle on `err_flags_o` or `err_irq_o`. A stale fault-edge register shows as a missing or repeated `auto_nack_o` on the cycle after a fault rises.

// File: rtl/i2c_err_pkg.sv
package i2c_err_pkg;
  localparam int unsigned NUM_ERR_FLAGS  = 3;
  localparam int unsigned NUM_BUF_FAULTS = 4;
  localparam int unsigned FLAG_TMO  = 0;
  localparam int unsigned FLAG_COLL = 1;
  localparam int unsigned FLAG_NACK = 2;

  typedef enum logic [1:0] {
    RS_IDLE    = 2'd0,
    RS_WAIT_SW = 2'd1,
    RS_STOP    = 2'd2
  } rcv_state_e;
endpackage

// File: rtl/i2c_err_flags.sv
module i2c_err_flags #(
  parameter int unsigned NUM_FLAGS = 3,
  parameter int unsigned FORCE_IDX = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  input  logic                 force_set_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 force_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
    end
  end

  // pending fault interrupt follows the lifetime of its flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) force_q <= 1'b0;
    else         force_q <= force_set_i | (force_q & ~clr_i[FORCE_IDX]);
  end

  assign flags_o = flag_q;
  assign irq_o   = (|(flag_q & en_i)) | force_q;
endmodule

// File: rtl/i2c_nack_ctl.sv
module i2c_nack_ctl #(
  parameter int unsigned NUM_FAULTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ninth_pulse_i,
  input  logic                  sda_i,
  input  logic                  client_act_i,
  input  logic                  host_act_i,
  input  logic [NUM_FAULTS-1:0] fault_i,
  output logic                  nack_set_o,
  output logic                  fault_hit_o,
  output logic                  auto_nack_o
);
  logic [NUM_FAULTS-1:0] prev_q;
  logic [NUM_FAULTS-1:0] rise;
  logic                  auto_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= fault_i;
  end

  assign rise        = fault_i & ~prev_q;
  assign fault_hit_o = |rise;
  assign nack_set_o  = (ninth_pulse_i & sda_i & (client_act_i | host_act_i)) | fault_hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) auto_q <= 1'b0;
    else         auto_q <= fault_hit_o;
  end

  assign auto_nack_o = auto_q;
endmodule

// File: rtl/i2c_tmo_recovery.sv
module i2c_tmo_recovery
  import i2c_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_i,
  input  logic host_mode_i,
  input  logic recov_en_i,
  input  logic host_act_i,
  input  logic stop_cmd_i,
  input  logic stop_done_i,
  input  logic scl_held_i,
  output logic soft_rst_o,
  output logic clr_client_act_o,
  output logic clr_clk_stretch_o,
  output logic clr_host_rdy_o,
  output logic stop_req_o,
  output logic clr_host_act_o
);
  rcv_state_e state_q, state_d;
  logic srst_q, cca_q, ccs_q, chr_q, cha_q;
  logic client_rec, host_tmo;

  assign client_rec = tmo_i & ~host_mode_i & recov_en_i;
  assign host_tmo   = tmo_i & host_mode_i & host_act_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:    if (host_tmo) state_d = recov_en_i ? RS_STOP : RS_WAIT_SW;
      RS_WAIT_SW: if (stop_cmd_i) state_d = RS_STOP;
      RS_STOP:    if (stop_done_i) state_d = RS_IDLE;
      default:    state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      srst_q  <= 1'b0;
      cca_q   <= 1'b0;
      ccs_q   <= 1'b0;
      chr_q   <= 1'b0;
      cha_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      srst_q  <= client_rec & ~srst_q;
      cca_q   <= client_rec;
      ccs_q   <= client_rec;
      chr_q   <= host_tmo;
      cha_q   <= (state_q == RS_STOP) & stop_done_i;
    end
  end

  assign soft_rst_o        = srst_q;
  assign clr_client_act_o  = cca_q;
  assign clr_clk_stretch_o = ccs_q;
  assign clr_host_rdy_o    = chr_q;
  assign clr_host_act_o    = cha_q;
  // request withheld while a client stretches the clock
  assign stop_req_o        = (state_q == RS_STOP) & ~scl_held_i;
endmodule

// File: rtl/i2c_err_recovery.sv
module i2c_err_recovery
  import i2c_err_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tmo_i,
  input  logic                      coll_i,
  input  logic                      ninth_pulse_i,
  input  logic                      sda_i,
  input  logic [NUM_BUF_FAULTS-1:0] buf_fault_i,
  input  logic                      client_act_i,
  input  logic                      host_act_i,
  input  logic                      host_mode_i,
  input  logic                      recov_en_i,
  input  logic                      stop_cmd_i,
  input  logic                      stop_done_i,
  input  logic                      scl_held_i,
  input  logic [NUM_ERR_FLAGS-1:0]  flag_clr_i,
  input  logic [NUM_ERR_FLAGS-1:0]  irq_en_i,
  output logic [NUM_ERR_FLAGS-1:0]  err_flags_o,
  output logic                      err_irq_o,
  output logic                      soft_rst_o,
  output logic                      clr_client_act_o,
  output logic                      clr_clk_stretch_o,
  output logic                      clr_host_rdy_o,
  output logic                      stop_req_o,
  output logic                      clr_host_act_o,
  output logic                      auto_nack_o
);
  logic                     nack_set, fault_hit;
  logic [NUM_ERR_FLAGS-1:0] flag_set;

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_TMO]  = tmo_i;
    flag_set[FLAG_COLL] = coll_i;
    flag_set[FLAG_NACK] = nack_set;
  end

  i2c_nack_ctl #(.NUM_FAULTS(NUM_BUF_FAULTS)) u_nack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ninth_pulse_i(ninth_pulse_i),
    .sda_i        (sda_i),
    .client_act_i (client_act_i),
    .host_act_i   (host_act_i),
    .fault_i      (buf_fault_i),
    .nack_set_o   (nack_set),
    .fault_hit_o  (fault_hit),
    .auto_nack_o  (auto_nack_o)
  );

  i2c_err_flags #(.NUM_FLAGS(NUM_ERR_FLAGS), .FORCE_IDX(FLAG_NACK)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (flag_set),
    .clr_i      (flag_clr_i),
    .en_i       (irq_en_i),
    .force_set_i(fault_hit),
    .flags_o    (err_flags_o),
    .irq_o      (err_irq_o)
  );

  i2c_tmo_recovery u_rcv (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .tmo_i            (tmo_i),
    .host_mode_i      (host_mode_i),
    .recov_en_i       (recov_en_i),
    .host_act_i       (host_act_i),
    .stop_cmd_i       (stop_cmd_i),
    .stop_done_i      (stop_done_i),
    .scl_held_i       (scl_held_i),
    .soft_rst_o       (soft_rst_o),
    .clr_client_act_o (clr_client_act_o),
    .clr_clk_stretch_o(clr_clk_stretch_o),
    .clr_host_rdy_o   (clr_host_rdy_o),
    .stop_req_o       (stop_req_o),
    .clr_host_act_o   (clr_host_act_o)
  );
endmodule

// File: rtl/i2c_err_recovery_chk.sv
module i2c_err_recovery_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmo_i,
  input logic       ninth_pulse_i,
  input logic       sda_i,
  input logic [3:0] buf_fault_i,
  input logic       client_act_i,
  input logic       host_act_i,
  input logic       host_mode_i,
  input logic       recov_en_i,
  input logic       stop_done_i,
  input logic       scl_held_i,
  input logic [2:0] flag_clr_i,
  input logic [2:0] err_flags_o,
  input logic       soft_rst_o,
  input logic       clr_client_act_o,
  input logic       clr_clk_stretch_o,
  input logic       clr_host_rdy_o,
  input logic       stop_req_o,
  input logic       clr_host_act_o,
  input logic       auto_nack_o
);
  a_r1_tmo_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> err_flags_o[0]);

  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flags_o[1] && !flag_clr_i[1]) |=> err_flags_o[1]);

  a_r3_client_recov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !host_mode_i && recov_en_i) |=> (clr_client_act_o && clr_clk_stretch_o));

  a_r5_host_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && host_mode_i && host_act_i) |=> clr_host_rdy_o);

  a_r6_scl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_held_i |-> !stop_req_o);

  a_r8_host_act_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_host_act_o |-> $past(stop_done_i));

  a_r9_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ninth_pulse_i && sda_i && (client_act_i || host_act_i)) |=> err_flags_o[2]);

  a_r10_auto_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_nack_o |-> $past(|buf_fault_i));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
endmodule

bind i2c_err_recovery i2c_err_recovery_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmo_i(tmo_i), .ninth_pulse_i(ninth_pulse_i),
  .sda_i(sda_i), .buf_fault_i(buf_fault_i), .client_act_i(client_act_i),
  .host_act_i(host_act_i), .host_mode_i(host_mode_i), .recov_en_i(recov_en_i),
  .stop_done_i(stop_done_i), .scl_held_i(scl_held_i), .flag_clr_i(flag_clr_i),
  .err_flags_o(err_flags_o), .soft_rst_o(soft_rst_o),
  .clr_client_act_o(clr_client_act_o), .clr_clk_stretch_o(clr_clk_stretch_o),
  .clr_host_rdy_o(clr_host_rdy_o), .stop_req_o(stop_req_o),
  .clr_host_act_o(clr_host_act_o), .auto_nack_o(auto_nack_o)
);

// File: tb/i2c_err_recovery_bench.sv
module i2c_err_recovery_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmo = 0, coll = 0, ninth = 0, sda = 0;
  logic [3:0] bfault = '0;
  logic cact = 0, hact = 0, hmode = 0, recov = 0;
  logic stop_cmd = 0, stop_done = 0, scl_held = 0;
  logic [2:0] fclr = '0, ien = '0;
  logic [2:0] flags;
  logic irq, srst, cca, ccs, chr, sreq, cha, anack;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_err_recovery u_i2c_err_recovery (
    .clk_i(clk), .rst_ni(rst_n), .tmo_i(tmo), .coll_i(coll),
    .ninth_pulse_i(ninth), .sda_i(sda), .buf_fault_i(bfault),
    .client_act_i(cact), .host_act_i(hact), .host_mode_i(hmode),
    .recov_en_i(recov), .stop_cmd_i(stop_cmd), .stop_done_i(stop_done),
    .scl_held_i(scl_held), .flag_clr_i(fclr), .irq_en_i(ien),
    .err_flags_o(flags), .err_irq_o(irq), .soft_rst_o(srst),
    .clr_client_act_o(cca), .clr_clk_stretch_o(ccs), .clr_host_rdy_o(chr),
    .stop_req_o(sreq), .clr_host_act_o(cha), .auto_nack_o(anack)
  );

  // stim {tmo,coll,hmode,recov,cact,hact} ; exp {flags[2:0],srst,cca,ccs,chr}
  localparam logic [12:0] VEC [8] = '{
    {6'b100110, 7'b0011110},
    {6'b100100, 7'b0011110},
    {6'b100010, 7'b0010000},
    {6'b010000, 7'b0100000},
    {6'b110000, 7'b0110000},
    {6'b101001, 7'b0010001},
    {6'b101100, 7'b0010000},
    {6'b101101, 7'b0010001}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    tmo = 0; coll = 0; ninth = 0; sda = 0; stop_cmd = 1; tick();
    stop_cmd = 0; stop_done = 1; tick();
    stop_done = 0; fclr = 3'b111; tick();
    fclr = 0; tick();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 reset", {flags, irq, srst, cca, ccs, chr, sreq, cha, anack}, '0);
    rst_n = 1; tick();

    // table: R1 R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      {tmo, coll, hmode, recov, cact, hact} = VEC[i][12:7];
      tick();
      tmo = 0; coll = 0;
      check($sformatf("R3 R4 R5 vec%0d", i), {flags, srst, cca, ccs, chr}, VEC[i][6:0]);
      check($sformatf("R2 vec%0d irq off", i), irq, 1'b0);
      clear_all();
    end

    // R2 enables
    coll = 1; tick(); coll = 0;
    ien = 3'b010; #1;
    check("R2 enabled irq", irq, 1'b1);
    ien = 3'b001; #1;
    check("R2 other enable", irq, 1'b0);
    ien = 0;
    // R1 sticky, clear, set-over-clear
    repeat (3) tick();
    check("R1 sticky", flags, 3'b010);
    fclr = 3'b010; coll = 1; tick(); fclr = 0; coll = 0;
    check("R1 set wins", flags, 3'b010);
    fclr = 3'b010; tick(); fclr = 0;
    check("R1 cleared", flags, 3'b000);

    // R6 stop waits for SCL release, R8 completion
    hmode = 1; recov = 1; hact = 1; scl_held = 1;
    tmo = 1; tick(); tmo = 0;
    check("R6 held", sreq, 1'b0);
    tick();
    scl_held = 0; #1;
    check("R6 released", sreq, 1'b1);
    repeat (3) tick();
    check("R6 level", sreq, 1'b1);
    stop_done = 1; tick(); stop_done = 0;
    check("R8 req drop", {sreq, cha}, 2'b01);
    tick();
    check("R8 single pulse", cha, 1'b0);

    // R7 manual stop
    recov = 0; stop_cmd = 1; tick(); stop_cmd = 0;
    check("R7 cmd ignored idle", sreq, 1'b0);
    tmo = 1; tick(); tmo = 0;
    repeat (2) tick();
    check("R7 waits sw", sreq, 1'b0);
    stop_cmd = 1; tick(); stop_cmd = 0;
    check("R7 stop after cmd", sreq, 1'b1);
    stop_done = 1; tick(); stop_done = 0;
    check("R8 manual done", {sreq, cha}, 2'b01);
    hmode = 0; hact = 0;
    fclr = 3'b111; tick(); fclr = 0;

    // R9 NACK detect
    ninth = 1; sda = 1; cact = 0; hact = 0; tick();
    check("R9 inactive", flags[2], 1'b0);
    sda = 0; cact = 1; tick();
    check("R9 sda low", flags[2], 1'b0);
    sda = 1; tick(); ninth = 0; sda = 0; cact = 0;
    check("R9 nack set", flags[2], 1'b1);
    fclr = 3'b100; tick(); fclr = 0;

    // R10 buffer fault
    bfault = 4'b1000; tick();
    check("R10 auto nack", {anack, flags[2], irq}, 3'b111);
    tick();
    check("R10 one pulse", anack, 1'b0);
    check("R10 irq held", irq, 1'b1);
    bfault = 0; fclr = 3'b100; tick(); fclr = 0;
    check("R10 irq cleared", {flags[2], irq}, 2'b00);

    // R11 back-to-back time-outs
    recov = 1; tmo = 1; tick();
    check("R11 first pulse", srst, 1'b1);
    tick(); tmo = 0;
    check("R11 no second", srst, 1'b0);
    tick();
    check("R11 flags survive", flags[0], 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule